// File: doc/BRIEF.md
# Wait-Stretched Strobe Sequencer

This block times one access on an asynchronous static-memory bus. On an accepted request it walks through three phases, each lasting a programmable number of clock cycles: a setup phase with both strobes inactive, a pulse phase with the read or write strobe driven low, and a hold phase with both strobes inactive again. A single-cycle completion pulse follows the hold phase, and the block returns to idle on the next cycle.

The memory device may slow an access with an active-low wait line. That line passes through a two-stage synchronizer, so the sequencer sees it two cycles after the device drives it. Two wait modes are available. In the freezing mode the pulse counter halts while the synchronized wait is active. In the ready mode only the last pulse cycle is held until wait is released. Because of the synchronizer, a wait that arrives too late in a short pulse is never seen: the access goes on into hold. To be sure a wait is caught, the pulse length must be at least the device's wait latency plus three cycles.

All timing fields, the direction and the wait mode are captured when a request is accepted. A request is accepted only while the block signals idle.

Top module: `wait_strobe_seq`

## Requirements
- R1: After reset the block is idle: `ready_o` is 1, both strobes are 1 and `done_o` is 0. `ready_o` is 1 only while idle, and both strobes are 1 whenever `ready_o` is 1.
- R2: When a request is accepted, both strobes stay 1 for exactly `setup_cyc_i` cycles (0 means no setup cycle). After that, only the selected strobe goes low: `rd_n_o` when `write_i` is 0 and `wr_n_o` when it is 1. The two strobes are never low together.
- R3: When wait is not active, the strobe stays low for exactly `pulse_cyc_i` cycles, and a value of 0 gives 1 cycle.
- R4: After the pulse, both strobes stay 1 for `hold_cyc_i` cycles (0 means none). Then `done_o` is 1 for exactly one cycle, and `ready_o` is 1 on the cycle after it. A request raised while `ready_o` is 0 has no effect.
- R5: The sequencer acts on the wait line only through a two-stage synchronizer. A level driven on `ext_wait_n_i` before clock edge n is used by the sequencer in the cycle after edge n+1.
- R6: With `wait_mode_i` = 2 (freeze), each pulse cycle in which the synchronized wait is active adds one cycle to the strobe. The remaining count resumes when wait is released.
- R7: With `wait_mode_i` = 3 (ready), the strobe cannot end while the synchronized wait is active on the last counted pulse cycle. A wait that is seen only on earlier pulse cycles does not lengthen the strobe.
- R8: With `wait_mode_i` = 0 or 1, the wait line has no effect on the strobe length.
- R9: A synchronized wait that first becomes active after the last pulse cycle is ignored in both wait modes, and the access proceeds through hold unstretched. With a pulse of 5 cycles, a wait driven up to 2 cycles after the strobe falls still stretches the strobe, and one driven 3 cycles after does not.
- R10: Timing fields, direction and wait mode are captured when the request is accepted. Changes to them during an access do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, taken when `ready_o` is 1 |
| write_i | input | 1 | 1 selects the write strobe, 0 selects the read strobe |
| setup_cyc_i | input | 6 | Setup phase length in cycles |
| pulse_cyc_i | input | 6 | Pulse phase length in cycles (0 acts as 1) |
| hold_cyc_i | input | 6 | Hold phase length in cycles |
| wait_mode_i | input | 2 | 2 = freeze, 3 = ready, other values = wait ignored |
| ext_wait_n_i | input | 1 | Asynchronous active-low wait from the device |
| ready_o | output | 1 | Idle and able to accept a request |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| done_o | output | 1 | One-cycle pulse at the end of an access |

## Verification
The hardest case to reach is a wait that arrives right at the detection edge, where one cycle of device latency decides whether the strobe is stretched or the access goes on into hold. To reach it, the stimulus counts cycles from the observed falling edge of the strobe and drives the wait line at a chosen latency and for a chosen width. It uses latencies on both sides of the minimum-pulse limit and runs each in both wait modes. It also places an early short wait in ready mode, which must leave the strobe unchanged, and changes the timing fields and raises a request in the middle of an access.

// File: rtl/wss_pkg.sv
package wss_pkg;
    localparam int CNT_W = 6;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_PULSE = 3'd2,
        PH_HOLD  = 3'd3,
        PH_DONE  = 3'd4
    } phase_e;

    localparam logic [1:0] WMODE_FREEZE = 2'd2;
    localparam logic [1:0] WMODE_READY  = 2'd3;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             is_wr;
        logic [1:0]       mode;
        logic [CNT_W-1:0] pulse;
        logic [CNT_W-1:0] hold;
    } seq_regs_t;
endpackage

// File: rtl/wss_sync.sv
module wss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wss_core.sv
module wss_core
    import wss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             write_i,
    input  logic [CNT_W-1:0] setup_cyc_i,
    input  logic [CNT_W-1:0] pulse_cyc_i,
    input  logic [CNT_W-1:0] hold_cyc_i,
    input  logic [1:0]       wait_mode_i,
    input  logic             wait_s_i,
    output phase_e           phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [1:0]       mode_o,
    output logic             is_wr_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_regs_t r_d, r_q;
    logic [CNT_W-1:0] pulse_eff;
    logic             last_cnt;
    logic             stall;

    always_comb begin
        r_d       = r_q;
        pulse_eff = (pulse_cyc_i == '0) ? ONE : pulse_cyc_i;
        last_cnt  = (r_q.cnt == ONE);
        stall     = 1'b0;
        if (r_q.phase == PH_PULSE && wait_s_i) begin
            if (r_q.mode == WMODE_FREEZE)                 stall = 1'b1;
            else if (r_q.mode == WMODE_READY && last_cnt) stall = 1'b1;
        end

        case (r_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    r_d.is_wr = write_i;
                    r_d.mode  = wait_mode_i;
                    r_d.pulse = pulse_eff;
                    r_d.hold  = hold_cyc_i;
                    if (setup_cyc_i != '0) begin
                        r_d.phase = PH_SETUP;
                        r_d.cnt   = setup_cyc_i;
                    end else begin
                        r_d.phase = PH_PULSE;
                        r_d.cnt   = pulse_eff;
                    end
                end
            end
            PH_SETUP: begin
                if (last_cnt) begin
                    r_d.phase = PH_PULSE;
                    r_d.cnt   = r_q.pulse;
                end else begin
                    r_d.cnt = r_q.cnt - ONE;
                end
            end
            PH_PULSE: begin
                if (!stall) begin
                    if (last_cnt) begin
                        if (r_q.hold != '0) begin
                            r_d.phase = PH_HOLD;
                            r_d.cnt   = r_q.hold;
                        end else begin
                            r_d.phase = PH_DONE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt - ONE;
                    end
                end
            end
            PH_HOLD: begin
                if (last_cnt) r_d.phase = PH_DONE;
                else          r_d.cnt   = r_q.cnt - ONE;
            end
            PH_DONE: r_d.phase = PH_IDLE;
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.phase <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign phase_o = r_q.phase;
    assign cnt_o   = r_q.cnt;
    assign mode_o  = r_q.mode;
    assign is_wr_o = r_q.is_wr;
endmodule

// File: rtl/wait_strobe_seq.sv
module wait_strobe_seq
    import wss_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             write_i,
    input  logic [CNT_W-1:0] setup_cyc_i,
    input  logic [CNT_W-1:0] pulse_cyc_i,
    input  logic [CNT_W-1:0] hold_cyc_i,
    input  logic [1:0]       wait_mode_i,
    input  logic             ext_wait_n_i,
    output logic             ready_o,
    output logic             rd_n_o,
    output logic             wr_n_o,
    output logic             done_o
);
    logic             wait_sync;
    phase_e           phase_w;
    logic [CNT_W-1:0] cnt_w;
    logic [1:0]       mode_w;
    logic             is_wr_w;

    wss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (~ext_wait_n_i),
        .sync_o  (wait_sync)
    );

    wss_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .write_i     (write_i),
        .setup_cyc_i (setup_cyc_i),
        .pulse_cyc_i (pulse_cyc_i),
        .hold_cyc_i  (hold_cyc_i),
        .wait_mode_i (wait_mode_i),
        .wait_s_i    (wait_sync),
        .phase_o     (phase_w),
        .cnt_o       (cnt_w),
        .mode_o      (mode_w),
        .is_wr_o     (is_wr_w)
    );

    assign ready_o = (phase_w == PH_IDLE);
    assign done_o  = (phase_w == PH_DONE);
    assign rd_n_o  = !((phase_w == PH_PULSE) && !is_wr_w);
    assign wr_n_o  = !((phase_w == PH_PULSE) &&  is_wr_w);
endmodule

// File: rtl/wss_checker.sv
module wss_checker
    import wss_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ext_wait_n,
    input logic             wait_s,
    input phase_e           phase,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0]       mode,
    input logic             rd_n,
    input logic             wr_n,
    input logic             done,
    input logic             ready
);
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 3) age_q <= age_q + 2'd1;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (rd_n && wr_n && !done)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready)); // R4
    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2) |-> (wait_s == !$past(ext_wait_n, 2))); // R5
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && mode == WMODE_FREEZE && wait_s)
        |=> (phase == PH_PULSE && cnt == $past(cnt))); // R6
    AST_READY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && mode == WMODE_READY && wait_s && cnt == 1)
        |=> (phase == PH_PULSE && cnt == 1)); // R7
    AST_NOWAIT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && mode != WMODE_FREEZE && mode != WMODE_READY && cnt > 1)
        |=> (phase == PH_PULSE && cnt == $past(cnt) - 6'd1)); // R8
endmodule

bind wait_strobe_seq wss_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_wait_n (ext_wait_n_i),
    .wait_s     (wait_sync),
    .phase      (phase_w),
    .cnt        (cnt_w),
    .mode       (mode_w),
    .rd_n       (rd_n_o),
    .wr_n       (wr_n_o),
    .done       (done_o),
    .ready      (ready_o)
);

// File: tb/wait_strobe_seq_tb.sv
module wait_strobe_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       wr = 1'b0;
    logic [5:0] setup_c = '0, pulse_c = '0, hold_c = '0;
    logic [1:0] wmode = '0;
    logic       ext_n = 1'b1;
    logic       ready, rd_n, wr_n, done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wait_strobe_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .write_i(wr),
        .setup_cyc_i(setup_c), .pulse_cyc_i(pulse_c), .hold_cyc_i(hold_c),
        .wait_mode_i(wmode), .ext_wait_n_i(ext_n),
        .ready_o(ready), .rd_n_o(rd_n), .wr_n_o(wr_n), .done_o(done)
    );

    // Behavioural reference: phase 0 idle,1 setup,2 strobe,3 hold,4 done
    int m_ph = 0, m_left = 0, m_pulse = 0, m_hold = 0, m_mode = 0;
    bit m_wr = 0;
    bit sq[$] = '{0, 0};

    always @(posedge clk) begin
        bit w_seen;
        if (!rst_n) begin
            m_ph = 0; sq = '{0, 0};
        end else begin
            w_seen = sq[0];
            sq.push_back(!ext_n);
            void'(sq.pop_front());
            case (m_ph)
                0: if (req) begin
                    m_wr = wr; m_mode = int'(wmode); m_hold = int'(hold_c);
                    m_pulse = (pulse_c == 0) ? 1 : int'(pulse_c);
                    if (setup_c != 0) begin m_ph = 1; m_left = int'(setup_c); end
                    else begin m_ph = 2; m_left = m_pulse; end
                end
                1: if (m_left == 1) begin m_ph = 2; m_left = m_pulse; end
                   else m_left--;
                2: if (!((m_mode == 2 && w_seen) || (m_mode == 3 && w_seen && m_left == 1))) begin
                       if (m_left > 1) m_left--;
                       else if (m_hold > 0) begin m_ph = 3; m_left = m_hold; end
                       else m_ph = 4;
                   end
                3: if (m_left == 1) m_ph = 4; else m_left--;
                default: m_ph = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req_tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp_v);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(ready == (m_ph == 0), "R1 ready", int'(ready), int'(m_ph == 0));
            chk(rd_n == !(m_ph == 2 && !m_wr), "R3 rd_n", int'(rd_n), int'(!(m_ph == 2 && !m_wr)));
            chk(wr_n == !(m_ph == 2 && m_wr), "R3 wr_n", int'(wr_n), int'(!(m_ph == 2 && m_wr)));
            chk(done == (m_ph == 4), "R4 done", int'(done), int'(m_ph == 4));
        end
    end

    task automatic run_acc(input bit w, input int s, input int p, input int h,
                           input int mode, input int lat, input int width,
                           input int exp_len, input bit poke, input string tag);
        int n_setup = 0, n_low = 0, n_hold = 0, t = -1, guard = 0;
        bit other_low = 0;
        @(negedge clk);
        wr = w; setup_c = 6'(s); pulse_c = 6'(p); hold_c = 6'(h); wmode = 2'(mode);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        // R10: scramble fields after acceptance
        setup_c = 6'd9; pulse_c = 6'd17; hold_c = 6'd7; wmode = 2'(mode ^ 1); wr = !w;
        while (!done && guard < 300) begin
            bit lo;
            lo = w ? !wr_n : !rd_n;
            if ((w ? !rd_n : !wr_n)) other_low = 1;
            if (lo) begin
                if (t < 0) t = 0;
                n_low++;
            end else if (t < 0) n_setup++;
            else n_hold++;
            if (t >= 0) begin
                ext_n = !(t >= lat && t < lat + width);
                if (poke && t == 1) req = 1'b1; else req = 1'b0;
                t++;
            end
            guard++;
            @(negedge clk);
        end
        req = 1'b0; ext_n = 1'b1;
        chk(done == 1'b1, {tag, " R4 done reached"}, int'(done), 1);
        chk(n_setup == s, {tag, " R2 setup cycles"}, n_setup, s);
        chk(n_low == exp_len, {tag, " strobe length"}, n_low, exp_len);
        chk(n_hold == h, {tag, " R4 hold cycles"}, n_hold, h);
        chk(!other_low, {tag, " R2 other strobe"}, int'(other_low), 0);
        @(negedge clk);
        chk(ready && !done, {tag, " R4 ready after done"}, int'(ready), 1);
        @(negedge clk);
        chk(ready && rd_n && wr_n, {tag, " R4 no stray access"}, int'(ready), 1);
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && rd_n && wr_n && !done, "R1 reset state", int'(ready), 1);
        // R3: plain pulses
        run_acc(0, 2, 4, 3, 0, 0, 0, 4, 0, "R3 read p4");
        run_acc(0, 1, 0, 1, 0, 0, 0, 1, 0, "R3 pulse zero");
        run_acc(1, 3, 6, 2, 0, 0, 0, 6, 0, "R2 write p6");
        run_acc(1, 0, 3, 0, 0, 0, 0, 3, 0, "R4 zero setup hold");
        // R6 / R5: freeze mode
        run_acc(0, 2, 5, 2, 2, 2, 3, 8, 0, "R6 freeze lat2");
        run_acc(0, 2, 5, 2, 2, 0, 2, 7, 0, "R6 freeze lat0");
        run_acc(1, 1, 5, 1, 2, 0, 1, 6, 0, "R5 freeze one");
        // R7: ready mode
        run_acc(0, 2, 5, 2, 3, 2, 3, 8, 0, "R7 ready lat2");
        run_acc(0, 2, 5, 2, 3, 0, 2, 5, 0, "R7 ready early");
        // R9: late wait
        run_acc(0, 2, 5, 2, 2, 3, 4, 5, 0, "R9 freeze late");
        run_acc(1, 2, 5, 2, 3, 3, 4, 5, 0, "R9 ready late");
        // R8: wait ignored when disabled
        run_acc(0, 1, 5, 1, 1, 0, 6, 5, 0, "R8 mode1");
        run_acc(0, 1, 5, 1, 0, 0, 6, 5, 0, "R8 mode0");
        // R10 / R4: mid-access request and field changes
        run_acc(0, 2, 4, 2, 0, 0, 0, 4, 1, "R10 busy req");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule